// File: doc/BRIEF.md
# Signed Remainder and Modulo Unit

This unit is the arithmetic back end for a small processor's remainder and modulo instructions. It takes a signed dividend, a signed divisor and an operation select. It returns one 16-bit signed result with zero and negative flags. Two operations are supported. The first is the truncating remainder, whose sign follows the dividend. The second is the floored modulo, whose sign follows the divisor. Operand selection and register writeback stay outside the unit. Immediate, two-register and three-register forms all arrive as the same pair of operands.

A start strobe launches an operation. If the divisor is non-zero, the operand magnitudes are loaded into a restoring divider that produces one quotient bit per cycle. A final adjust cycle then applies the sign correction and, for modulo, the divisor correction. A zero divisor skips the divider and completes at once. Control is a three-state machine:

- IDLE waits for start.
- DIVIDE runs the 16 shift-subtract steps.
- ADJUST registers the corrected result.

Its transitions are:

- launch: IDLE to DIVIDE, on start with a non-zero divisor.
- zero-exit: IDLE to IDLE with done, on start with a zero divisor.
- last-step: DIVIDE to ADJUST, after the sixteenth step.
- finish: ADJUST to IDLE, with done.

Top module: `srm_unit`

## Requirements
- R1: With op_mod = 0, result equals a − b·trunc(a/b), so a non-zero result carries the sign of the dividend.
- R2: With op_mod = 1, result equals (b + (a rem b)) rem b, so a non-zero result carries the sign of the divisor.
- R3: Full-range operands are handled, and −32768 with divisor −1 gives 0 for both operations with no overflow.
- R4: flag_z is 1 exactly when the completed 16-bit result is zero.
- R5: flag_n equals bit 15 of the completed result.
- R6: A zero divisor gives result 0, div_zero = 1 and flag_z = 1, with done in the cycle right after the accepting clock edge.
- R7: A non-zero divisor raises busy in the cycle after the accepting edge and keeps it high for 17 cycles. done is high for exactly one cycle, the 18th after the accepting edge, when busy falls.
- R8: start is ignored while busy is high, and the operation in flight completes unaffected.
- R9: result, flags and div_zero hold their values between completions, and a completion with a non-zero divisor clears div_zero.
- R10: After reset, busy, done, result, flag_z, flag_n and div_zero are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, sampled while idle |
| op_mod | input | 1 | 0 = truncating remainder, 1 = floored modulo |
| dividend | input | 16 | Signed dividend a |
| divisor | input | 16 | Signed divisor b |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Signed result |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 15 |
| div_zero | output | 1 | Last operation had a zero divisor |

## Verification
The checker examines every cycle for the following:

- consistency between the flags and the result at completion (R4, R5),
- the zero-result and one-cycle completion of zero-divisor operations (R6),
- the exact 17-cycle busy window ending in done (R7),
- busy rising after a non-zero launch (R7),
- the absence of any completion while busy and not finishing (R8).

The arithmetic values cannot be shown by these properties. The bench's sweeps show them instead. These cover the truncating and floored sign rules across all sign combinations (R1, R2), the −32768 corner cases (R3), the retention of outputs between operations (R9), and the fact that a stray start during an operation leaves its result intact (R8).

// File: rtl/srm_pkg.sv
package srm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_ADJUST = 2'd2
    } srm_state_e;

    typedef enum logic {
        OP_REM = 1'b0,
        OP_MOD = 1'b1
    } srm_op_e;

endpackage

// File: rtl/srm_absval.sv
module srm_absval #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] mag,
    output logic         neg
);
    // The unsigned magnitude of the most negative value is 2^(W-1), which fits in W bits.
    always_comb begin
        neg = val[W-1];
        mag = neg ? (~val + W'(1)) : val;
    end
endmodule

// File: rtl/srm_magdiv.sv
module srm_magdiv #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] num_mag,
    input  logic [W-1:0] den_mag,
    output logic [W-1:0] rem_mag
);
    localparam int PW = W + 1;

    logic [PW-1:0] part_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [PW-1:0] shifted;
    logic [PW-1:0] trial;
    logic          restore;

    // One restoring step: shift in the next dividend bit, try a subtraction, keep it if non-negative.
    always_comb begin
        shifted = {part_q[W-1:0], quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
        restore = trial[PW-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            quo_q  <= '0;
            den_q  <= '0;
        end else if (load) begin
            part_q <= '0;
            quo_q  <= num_mag;
            den_q  <= den_mag;
        end else if (step) begin
            part_q <= restore ? shifted : trial;
            quo_q  <= {quo_q[W-2:0], ~restore};
        end
    end

    assign rem_mag = part_q[W-1:0];
endmodule

// File: rtl/srm_signfix.sv
module srm_signfix #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_mag,
    input  logic         neg_a,
    input  logic [W-1:0] den,
    input  logic         want_mod,
    output logic [W-1:0] fixed
);
    logic [W-1:0] rem_s;
    logic         nonzero;
    logic         sign_mismatch;

    always_comb begin
        // The truncating remainder takes the dividend's sign.
        rem_s         = neg_a ? (W'(0) - rem_mag) : rem_mag;
        nonzero       = (rem_mag != '0);
        sign_mismatch = (neg_a != den[W-1]);
        // Floored modulo: shift a non-zero remainder by one divisor when the signs disagree.
        if (want_mod && nonzero && sign_mismatch)
            fixed = rem_s + den;
        else
            fixed = rem_s;
    end
endmodule

// File: rtl/srm_unit.sv
module srm_unit
    import srm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_mod,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic         flag_z,
    output logic         flag_n,
    output logic         div_zero
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    srm_state_e    state_q, state_d;
    logic [CW-1:0] step_q;

    logic [W-1:0]  a_mag, b_mag, rem_mag, fixed;
    logic          a_neg, b_neg_unused;
    logic          div_is_zero, launch, stepping;

    logic          hold_neg_a;
    logic [W-1:0]  hold_den;
    logic          hold_mod;

    logic [W-1:0]  result_q;
    logic          done_q, z_q, n_q, dz_q;

    assign div_is_zero = (divisor == '0);
    assign launch      = (state_q == ST_IDLE) && start && !div_is_zero;
    assign stepping    = (state_q == ST_DIVIDE);

    srm_absval #(.W(W)) u_abs_a (.val(dividend), .mag(a_mag), .neg(a_neg));
    srm_absval #(.W(W)) u_abs_b (.val(divisor),  .mag(b_mag), .neg(b_neg_unused));

    srm_magdiv #(.W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .step    (stepping),
        .num_mag (a_mag),
        .den_mag (b_mag),
        .rem_mag (rem_mag)
    );

    srm_signfix #(.W(W)) u_fix (
        .rem_mag  (rem_mag),
        .neg_a    (hold_neg_a),
        .den      (hold_den),
        .want_mod (hold_mod),
        .fixed    (fixed)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_DIVIDE;
            ST_DIVIDE: if (step_q == LAST_STEP) state_d = ST_ADJUST;
            ST_ADJUST: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DIVIDE)
                step_q <= step_q + CW'(1);
            else
                step_q <= '0;
        end
    end

    // Output and operand-hold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q   <= '0;
            done_q     <= 1'b0;
            z_q        <= 1'b0;
            n_q        <= 1'b0;
            dz_q       <= 1'b0;
            hold_neg_a <= 1'b0;
            hold_den   <= '0;
            hold_mod   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && div_is_zero) begin
                        result_q <= '0;
                        z_q      <= 1'b1;
                        n_q      <= 1'b0;
                        dz_q     <= 1'b1;
                        done_q   <= 1'b1;
                    end else if (start) begin
                        hold_neg_a <= a_neg;
                        hold_den   <= divisor;
                        hold_mod   <= (srm_op_e'(op_mod) == OP_MOD);
                    end
                end
                ST_DIVIDE: begin
                end
                ST_ADJUST: begin
                    result_q <= fixed;
                    z_q      <= (fixed == '0);
                    n_q      <= fixed[W-1];
                    dz_q     <= 1'b0;
                    done_q   <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign result   = result_q;
    assign flag_z   = z_q;
    assign flag_n   = n_q;
    assign div_zero = dz_q;
endmodule

// File: rtl/srm_unit_chk.sv
module srm_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         op_mod,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_n,
    input logic         div_zero
);
    localparam int BUSY_CYCLES = W + 1;
    localparam int KW = $clog2(BUSY_CYCLES + 2) + 1;

    logic [KW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            busy_cnt <= '0;
        else
            busy_cnt <= busy_cnt + KW'(1);
    end

    p_zflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (result == '0)));

    p_nflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_n == result[W-1]));

    p_divzero_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && div_zero && flag_z && result == '0));

    p_launch_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor != '0) |=> (busy && !done));

    p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && busy_cnt == KW'(BUSY_CYCLES)));

    p_no_early_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

bind srm_unit srm_unit_chk #(.W(W)) u_chk (.*);

// File: tb/srm_unit_test.sv
module srm_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_mod = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, flag_z, flag_n, div_zero;
    logic [15:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    srm_unit #(.W(16)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_mod(op_mod),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .result(result), .flag_z(flag_z), .flag_n(flag_n), .div_zero(div_zero)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int expect_val(input int a, input int b, input bit m);
        int r;
        r = a % b;
        if (m) r = (b + r) % b;
        return r;
    endfunction

    // Launch one operation and check its outcome; the start pulse lasts one cycle.
    task automatic run_op(input int a, input int b, input bit m, input string tag);
        int lat;
        int e;
        logic [15:0] e16;
        @(negedge clk);
        dividend = a[15:0]; divisor = b[15:0]; op_mod = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        if (b == 0) begin
            check(lat == 1, "R6 latency", lat, 1);
            check(result == 16'd0 && div_zero && flag_z, "R6 zero-divisor outputs",
                  int'($signed(result)), 0);
        end else begin
            e = expect_val(a, b, m);
            e16 = e[15:0];
            check(lat == 18, "R7 latency", lat, 18);
            check(result == e16, tag, int'($signed(result)), e);
            check(flag_z == (e16 == 16'd0), "R4 zero flag", flag_z, int'(e16 == 16'd0));
            check(flag_n == e16[15], "R5 negative flag", flag_n, e16[15]);
            check(!div_zero, "R9 div_zero cleared", div_zero, 0);
        end
        @(negedge clk);
        check(!done, "R7 done single cycle", done, 0);
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [15:0] held;
        int lat;
        repeat (3) @(negedge clk);
        check(!busy && !done && result == 16'd0 && !flag_z && !flag_n && !div_zero,
              "R10 reset state", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !div_zero, "R10 after reset release", busy, 0);

        // Sweep both operations over every sign combination (R1, R2, R6)
        for (int m = 0; m < 2; m++) begin
            for (int b = -9; b <= 9; b++) begin
                for (int a = -40; a <= 40; a++) begin
                    run_op(a, b, m[0], m ? "R2 modulo" : "R1 remainder");
                end
            end
        end

        // Full-range corners (R3)
        run_op(-32768, -1, 1'b0, "R3 min rem -1");
        run_op(-32768, -1, 1'b1, "R3 min mod -1");
        run_op(-32768, 1, 1'b1, "R3 min mod 1");
        run_op(-32768, 32767, 1'b0, "R3 min rem max");
        run_op(-32768, 32767, 1'b1, "R3 min mod max");
        run_op(32767, -32768, 1'b0, "R3 max rem min");
        run_op(32767, -32768, 1'b1, "R3 max mod min");
        run_op(-32768, -32768, 1'b1, "R3 min mod min");
        run_op(32767, 3, 1'b1, "R3 max mod 3");
        run_op(-32767, 2, 1'b1, "R3 mod odd");
        run_op(12345, -1000, 1'b1, "R3 mixed mod");
        run_op(-12345, 1000, 1'b0, "R3 mixed rem");

        // Hold between completions (R9)
        run_op(-17, 5, 1'b1, "R2 modulo before hold");
        held = result;
        repeat (6) @(negedge clk);
        check(result == held && !done && flag_n == held[15], "R9 result held",
              int'($signed(result)), int'($signed(held)));
        run_op(9, 0, 1'b0, "R6 zero divisor");
        repeat (4) @(negedge clk);
        check(div_zero && result == 16'd0, "R9 div_zero held", div_zero, 1);

        // Start while busy is ignored (R8)
        @(negedge clk);
        dividend = 16'hFF9C; divisor = 16'd7; op_mod = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        dividend = 16'd5; divisor = 16'd0; op_mod = 1'b1; start = 1'b1;
        @(negedge clk);
        lat++;
        check(!done && busy, "R8 no response to start while busy", done, 0);
        start = 1'b0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        check(lat == 18, "R8 latency unaffected", lat, 18);
        check(result == 16'hFFFE && !div_zero, "R8 result of first op",
              int'($signed(result)), -2);
        @(negedge clk);
        check(!done && !busy, "R8 no extra completion", done, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule